// File: doc/BRIEF.md
# Front-Panel I/O Register Decoder

This block sits between a host microprocessor bus and a small bank of I/O registers on a plotter control board. The host announces an access with a start strobe that carries a two-bit register select. The block captures the select and holds it until the access completes. The access counts only when the register-access line is low and the synchronous completion strobe, which marks the bus data as valid, is high. A qualified access raises an I/O-hit output. Depending on the captured select and the read/write line, the block then does one of four things: it returns the front-panel switches on the shared data bus, latches the indicator lamps and pen-position state, returns the pen status bits, or loads the interpolator data latch and raises the power-high flag.

Read data leaves on a bidirectional bus through tri-state drivers. The block releases the bus in every cycle that is not a qualified read. The write registers load from the same bus at the clock edge that ends a qualified write. The lamp bits on the bus are active-low.

Top module: `fpio_decoder`

## Requirements
- R1: The register select is captured at each rising edge where `start_stb` is high. Later changes on `addr_sel` have no effect on the access in progress.
- R2: `io_hit` is high only when a select has been captured, `reg_acc_n` is low, `sync_done` is high and the captured select is 0 or 1. Select 1 is the panel register. Select 0 is the pen/interpolator register.
- R3: An access with `reg_acc_n` high or `sync_done` low does not raise `io_hit`, does not drive the bus and changes no register.
- R4: Every rising edge with `sync_done` high and `start_stb` low ends the captured access. A captured access survives cycles in which `sync_done` is low. A strobe at the same edge re-arms the block with the new select.
- R5: A qualified read of select 1 (`rd_nwr`=1) drives `sw_in` onto `data_bus`.
- R6: A qualified write of select 1 stores `lamp_on[i]` = NOT `data_bus[i]` for i in 0..3 and `pen_pos` = `data_bus[5:4]`. Lamp bit 0 is LOAD, bit 1 is ENTER, bit 2 is WINDOW and bit 3 is ERROR.
- R7: A qualified read of select 0 drives bit 0 = `pen_sel`, bit 1 = `pen_arm`, bit 2 = `pen_stable` and zeros above.
- R8: A qualified write of select 0 loads `interp_data` from `data_bus` and sets `power_hi` at the same edge.
- R9: `bus_drive_en` is high only during a qualified read, and at most one read source drives in any cycle. Otherwise the bus is released.
- R10: A synchronous reset turns all lamps off and clears `pen_pos`, `interp_data`, `power_hi` and the captured access.
- R11: Selects 2 and 3 never raise `io_hit` and never change a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_sel | input | 2 | Register select lines |
| start_stb | input | 1 | Start-of-access strobe, captures the select |
| reg_acc_n | input | 1 | Register-access qualifier, active low |
| sync_done | input | 1 | Completion strobe, bus data valid |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| sw_in | input | 8 | Front-panel switch data |
| pen_sel | input | 1 | Pen-select status |
| pen_arm | input | 1 | Pen-armed status |
| pen_stable | input | 1 | Stable status |
| data_bus | inout | 8 | Bidirectional data bus |
| io_hit | output | 1 | Qualified I/O-register access |
| bus_drive_en | output | 1 | Block is driving data_bus |
| lamp_on | output | 4 | Lamp states, 1 = lit |
| pen_pos | output | 2 | Stored pen-position state |
| interp_data | output | 8 | Interpolator data latch |
| power_hi | output | 1 | Power-high flag |

## Verification
Two events can coincide at one clock edge: the completion strobe that ends an access, and a new start strobe that re-arms with a different select. The bench provokes this by raising `start_stb` with a new select during the qualified cycle of a write. It then checks that the write landed in the register named by the old select. It also checks that the following completion, with no further strobe, hits the register named by the new select. A sweep over every select, direction, qualifier and completion combination with varied data judges the other outcomes against a register model kept in the bench.

// File: rtl/fpio_pkg.sv
package fpio_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_PANEL_RD,
    OP_PANEL_WR,
    OP_PEN_RD,
    OP_INTERP_WR
  } io_op_e;

  localparam logic [1:0] SEL_PEN   = 2'b00;
  localparam logic [1:0] SEL_PANEL = 2'b01;

  // Bus bits are active-low for lamps: a low bit lights its lamp.
  function automatic logic [3:0] lamps_from_bus(input logic [3:0] bits);
    return ~bits;
  endfunction

  // Pen status word, select in bit 0, armed in bit 1, stable in bit 2.
  function automatic logic [2:0] pen_word(input logic sel, input logic arm,
                                          input logic stb);
    return {stb, arm, sel};
  endfunction
endpackage

// File: rtl/fpio_qualify.sv
module fpio_qualify
  import fpio_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] addr_sel,
  input  logic             start_stb,
  input  logic             reg_acc_n,
  input  logic             sync_done,
  input  logic             rd_nwr,
  output logic             io_hit,
  output io_op_e           op
);
  logic             armed_q;
  logic [SEL_W-1:0] sel_q;
  logic             in_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      sel_q   <= '0;
    end else if (start_stb) begin
      armed_q <= 1'b1;
      sel_q   <= addr_sel;
    end else if (sync_done) begin
      armed_q <= 1'b0;
    end
  end

  assign in_bank = (sel_q[SEL_W-1:1] == '0);
  assign io_hit  = armed_q & ~reg_acc_n & sync_done & in_bank;

  always_comb begin
    op = OP_NONE;
    if (io_hit) begin
      if (sel_q[0]) op = rd_nwr ? OP_PANEL_RD : OP_PANEL_WR;
      else          op = rd_nwr ? OP_PEN_RD   : OP_INTERP_WR;
    end
  end

  // R4
  access_end_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_done && !start_stb) |=> !io_hit);
endmodule

// File: rtl/fpio_read_drv.sv
module fpio_read_drv
  import fpio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  io_op_e        op,
  input  logic [DW-1:0] sw_in,
  input  logic          pen_sel,
  input  logic          pen_arm,
  input  logic          pen_stable,
  output logic          drive_en,
  output logic [DW-1:0] rd_word
);
  localparam int PEN_BITS = 3;
  logic rd_panel, rd_pen;

  assign rd_panel = (op == OP_PANEL_RD);
  assign rd_pen   = (op == OP_PEN_RD);
  assign drive_en = rd_panel | rd_pen;

  always_comb begin
    rd_word = '0;
    if (rd_panel) rd_word = sw_in;
    else if (rd_pen)
      rd_word = {{(DW-PEN_BITS){1'b0}}, pen_word(pen_sel, pen_arm, pen_stable)};
  end

  // R9
  one_reader_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_panel, rd_pen}));
endmodule

// File: rtl/fpio_wr_regs.sv
module fpio_wr_regs
  import fpio_pkg::*;
#(
  parameter int DW     = 8,
  parameter int LAMP_N = 4,
  parameter int POS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  io_op_e            op,
  input  logic [DW-1:0]     bus_in,
  output logic [LAMP_N-1:0] lamp_on,
  output logic [POS_W-1:0]  pen_pos,
  output logic [DW-1:0]     interp_data,
  output logic              power_hi
);
  localparam int POS_LO = LAMP_N;
  localparam int POS_HI = LAMP_N + POS_W - 1;

  logic wr_panel, wr_interp;
  assign wr_panel  = (op == OP_PANEL_WR);
  assign wr_interp = (op == OP_INTERP_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      lamp_on <= '0;
      pen_pos <= '0;
    end else if (wr_panel) begin
      lamp_on <= lamps_from_bus(bus_in[LAMP_N-1:0]);
      pen_pos <= bus_in[POS_HI:POS_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      interp_data <= '0;
      power_hi    <= 1'b0;
    end else if (wr_interp) begin
      interp_data <= bus_in;
      power_hi    <= 1'b1;
    end
  end

  // R6
  panel_reg_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({lamp_on, pen_pos}) |-> ($past(wr_panel) || $past(rst)));

  // R8
  power_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(power_hi) |-> $past(wr_interp));
endmodule

// File: rtl/fpio_decoder.sv
module fpio_decoder
  import fpio_pkg::*;
#(
  parameter int DW     = 8,
  parameter int SEL_W  = 2,
  parameter int LAMP_N = 4,
  parameter int POS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic              start_stb,
  input  logic              reg_acc_n,
  input  logic              sync_done,
  input  logic              rd_nwr,
  input  logic [DW-1:0]     sw_in,
  input  logic              pen_sel,
  input  logic              pen_arm,
  input  logic              pen_stable,
  inout  wire  [DW-1:0]     data_bus,
  output logic              io_hit,
  output logic              bus_drive_en,
  output logic [LAMP_N-1:0] lamp_on,
  output logic [POS_W-1:0]  pen_pos,
  output logic [DW-1:0]     interp_data,
  output logic              power_hi
);
  io_op_e        op;
  logic [DW-1:0] rd_word;

  fpio_qualify #(.SEL_W(SEL_W)) u_qual (
    .clk(clk), .rst(rst), .addr_sel(addr_sel), .start_stb(start_stb),
    .reg_acc_n(reg_acc_n), .sync_done(sync_done), .rd_nwr(rd_nwr),
    .io_hit(io_hit), .op(op)
  );

  fpio_read_drv #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .op(op), .sw_in(sw_in), .pen_sel(pen_sel),
    .pen_arm(pen_arm), .pen_stable(pen_stable),
    .drive_en(bus_drive_en), .rd_word(rd_word)
  );

  fpio_wr_regs #(.DW(DW), .LAMP_N(LAMP_N), .POS_W(POS_W)) u_wr (
    .clk(clk), .rst(rst), .op(op), .bus_in(data_bus),
    .lamp_on(lamp_on), .pen_pos(pen_pos),
    .interp_data(interp_data), .power_hi(power_hi)
  );

  assign data_bus = bus_drive_en ? rd_word : {DW{1'bz}};

  // R9
  drive_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    bus_drive_en |-> io_hit);

  // R3
  unqualified_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_acc_n || !sync_done) |-> (!io_hit && !bus_drive_en));
endmodule

// File: tb/fpio_decoder_tb.sv
module fpio_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr_sel = '0;
  logic       start_stb = 1'b0, reg_acc_n = 1'b1, sync_done = 1'b0, rd_nwr = 1'b1;
  logic [7:0] sw_in = '0;
  logic       pen_sel = 1'b0, pen_arm = 1'b0, pen_stable = 1'b0;
  wire  [7:0] data_bus;
  logic       io_hit, bus_drive_en, power_hi;
  logic [3:0] lamp_on;
  logic [1:0] pen_pos;
  logic [7:0] interp_data;
  logic       tb_drv = 1'b0;
  logic [7:0] tb_val = '0;

  int checks = 0, errors = 0;
  logic [3:0] m_lamp = '0;
  logic [1:0] m_pos = '0;
  logic [7:0] m_interp = '0;
  logic       m_power = 1'b0;

  assign data_bus = tb_drv ? tb_val : 8'bz;
  always #(CLK_PERIOD/2) clk = ~clk;

  fpio_decoder u_dut (
    .clk(clk), .rst(rst), .addr_sel(addr_sel), .start_stb(start_stb),
    .reg_acc_n(reg_acc_n), .sync_done(sync_done), .rd_nwr(rd_nwr),
    .sw_in(sw_in), .pen_sel(pen_sel), .pen_arm(pen_arm),
    .pen_stable(pen_stable), .data_bus(data_bus), .io_hit(io_hit),
    .bus_drive_en(bus_drive_en), .lamp_on(lamp_on), .pen_pos(pen_pos),
    .interp_data(interp_data), .power_hi(power_hi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check({req, " lamps"}, 32'(lamp_on), 32'(m_lamp));
    check({req, " pen_pos"}, 32'(pen_pos), 32'(m_pos));
    check({req, " interp"}, 32'(interp_data), 32'(m_interp));
    check({req, " power"}, 32'(power_hi), 32'(m_power));
  endtask

  task automatic model_write(input logic [1:0] sel, input logic [7:0] d);
    if (sel == 2'd1) begin m_lamp = ~d[3:0]; m_pos = d[5:4]; end
    else if (sel == 2'd0) begin m_interp = d; m_power = 1'b1; end
  endtask

  // Arm with sel, then one access cycle, then settle; checks everything.
  task automatic access(input logic [1:0] sel, input logic rd, input logic rac,
                        input logic smc, input logic [7:0] d);
    logic hit_exp;
    logic [7:0] rexp;
    @(negedge clk);
    start_stb = 1'b1; addr_sel = sel; sync_done = 1'b0; reg_acc_n = 1'b1;
    @(negedge clk);
    start_stb = 1'b0; addr_sel = ~sel;  // R1: later select changes ignored
    reg_acc_n = rac; sync_done = smc; rd_nwr = rd;
    tb_drv = !rd; tb_val = d;
    sw_in = d ^ 8'h5A;
    {pen_stable, pen_arm, pen_sel} = d[2:0];
    #1;
    hit_exp = (sel < 2'd2) && !rac && smc;
    rexp = (sel == 2'd1) ? sw_in : {5'b0, d[2:0]};
    check("R2/R3/R11 io_hit", 32'(io_hit), 32'(hit_exp));
    check("R9 bus_drive_en", 32'(bus_drive_en), 32'(hit_exp && rd));
    if (hit_exp && rd) begin
      if (sel == 2'd1) check("R5 panel read data", 32'(data_bus), 32'(rexp));
      else check("R7 pen read data", 32'(data_bus), 32'(rexp));
    end
    if (hit_exp && !rd) model_write(sel, d);
    @(negedge clk);
    sync_done = 1'b0; reg_acc_n = 1'b1; tb_drv = 1'b0;
    #1;
    check_regs(hit_exp ? (rd ? "R3 read leaves regs" : "R6/R8 write") : "R3/R11 no change");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check_regs("R10 reset");
    check("R10 no hit in reset", 32'(io_hit), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // Sweep: every select, direction, qualifier, completion, four data values
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 2; r++)
        for (int q = 0; q < 2; q++)
          for (int c = 0; c < 2; c++)
            for (int k = 0; k < 4; k++)
              access(2'(s), r[0], q[0], c[0], 8'($urandom));

    // R6 lamp mapping: only bit 2 low -> only WINDOW lit
    access(2'd1, 1'b0, 1'b0, 1'b1, 8'b0010_1011);
    check("R6 WINDOW only", 32'(lamp_on), 32'b0100);
    check("R6 pen_pos", 32'(pen_pos), 32'd2);

    // R4: completion consumed, a second completion without strobe misses
    access(2'd0, 1'b0, 1'b0, 1'b1, 8'hC3);
    @(negedge clk);
    sync_done = 1'b1; reg_acc_n = 1'b0; rd_nwr = 1'b0; tb_drv = 1'b1; tb_val = 8'h11;
    #1;
    check("R4 no hit after completion", 32'(io_hit), 32'd0);
    @(negedge clk);
    sync_done = 1'b0; reg_acc_n = 1'b1; tb_drv = 1'b0;
    #1;
    check("R4 interp unchanged", 32'(interp_data), 32'(m_interp));

    // R4: wait state with sync_done low keeps the access armed
    @(negedge clk);
    start_stb = 1'b1; addr_sel = 2'd1;
    @(negedge clk);
    start_stb = 1'b0; reg_acc_n = 1'b0; rd_nwr = 1'b1; sw_in = 8'hA7;
    @(negedge clk);
    sync_done = 1'b1;
    #1;
    check("R4 hit after wait state", 32'(io_hit), 32'd1);
    check("R5 data after wait", 32'(data_bus), 32'hA7);

    // R4: completion and new strobe at the same edge
    @(negedge clk);
    start_stb = 1'b1; addr_sel = 2'd0; sync_done = 1'b0;
    @(negedge clk);
    addr_sel = 2'd1; rd_nwr = 1'b0; sync_done = 1'b1; tb_drv = 1'b1; tb_val = 8'h3C;
    #1;
    model_write(2'd0, 8'h3C);
    @(negedge clk);
    start_stb = 1'b0; addr_sel = 2'd3; tb_val = 8'h0F;
    #1;
    check("R4 old select written", 32'(interp_data), 32'(m_interp));
    check("R4 re-armed hit", 32'(io_hit), 32'd1);
    model_write(2'd1, 8'h0F);
    @(negedge clk);
    sync_done = 1'b0; reg_acc_n = 1'b1; tb_drv = 1'b0;
    #1;
    check("R4 new select written", 32'(lamp_on), 32'(m_lamp));

    // R10: reset in mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_lamp = '0; m_pos = '0; m_interp = '0; m_power = 1'b0;
    #1;
    check_regs("R10 reset mid-run");
    @(negedge clk);
    sync_done = 1'b1; reg_acc_n = 1'b0;
    #1;
    check("R10 access cleared", 32'(io_hit), 32'd0);
    sync_done = 1'b0; reg_acc_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule